// File: doc/BRIEF.md
# Peripheral Autopoll Scheduler

This block paces background polling of a shared peripheral bus. Once enabled, it counts whole milliseconds from a clock-derived prescaler. Each time the programmed interval runs out, it raises a single-cycle poll request that carries the current 16-bit device selection mask. The interval then starts again by itself. Turning the enable on starts a fresh interval. Turning it off stops the schedule and cancels any expiry that is still pending. Writing a new interval while running restarts the count using the new value.

The bus engine answers a poll request with a result: a length and up to `MAX_BYTES` data bytes on a flat bus. If the result is not empty, the block wraps it into an unsolicited packet for the host. The packet is a bus-type byte, then a fixed polled-data marker, then the result bytes, and it leaves through a byte stream with valid, ready and last. An empty result produces no packet. While a packet is still waiting to be read, a new result is discarded and the packet in flight is left as it was.

Top module: `autopoll_sched`

## Requirements
- R1: After reset the schedule is stopped, `poll_req` and `pkt_valid` are low, `poll_mask` is all ones, and the stored interval is 20 ms.
- R2: A write that changes the enable from 0 to 1 in cycle c makes the first `poll_req` pulse appear exactly N·T+1 cycles later. Here N is the stored interval in ms and T = CLK_HZ/1000.
- R3: While enabled, successive `poll_req` pulses are exactly N·T cycles apart, and each pulse lasts one cycle.
- R4: A write that changes the enable from 1 to 0 stops polling: no `poll_req` appears until the block is enabled again.
- R5: An enable write equal to the current enable state leaves the schedule unchanged.
- R6: An interval write of a non-zero value while enabled restarts the count, so the next pulse follows after N_new·T+1 cycles. The same write while disabled only stores the value.
- R7: An interval write of zero is ignored, both the stored value and the running count.
- R8: `poll_mask` shows the last mask written, and is valid alongside each `poll_req`. A mask write does not move the schedule.
- R9: A result of length L (1..MAX_BYTES) produces a packet of L+2 bytes. Byte 0 is 0x00, byte 1 is 0x40, and then come `res_data[7:0]`, `res_data[15:8]` and so on. `pkt_last` is high on the final byte, each byte is held until taken with `pkt_ready`, and `pkt_valid` drops after the last byte is taken.
- R10: A result of length 0 produces no packet and does not disturb the schedule.
- R11: A result that arrives while a packet is still pending is dropped. The pending packet is delivered unchanged.
- R12: A length above MAX_BYTES is treated as MAX_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en_wr | input | 1 | Enable write strobe |
| cfg_en | input | 1 | Enable value for the write |
| cfg_rate_wr | input | 1 | Interval write strobe |
| cfg_rate | input | RATE_W | Interval in milliseconds |
| cfg_mask_wr | input | 1 | Device mask write strobe |
| cfg_mask | input | MASK_W | Device mask value |
| poll_req | output | 1 | One-cycle poll request |
| poll_mask | output | MASK_W | Devices to poll |
| res_valid | input | 1 | Poll result strobe |
| res_len | input | LEN_W | Result byte count |
| res_data | input | 8·MAX_BYTES | Result bytes, first byte in bits 7:0 |
| pkt_valid | output | 1 | Packet byte available |
| pkt_data | output | 8 | Packet byte |
| pkt_last | output | 1 | Final byte of packet |
| pkt_ready | input | 1 | Consumer takes the byte |

## Verification
Errors in the millisecond counter or the prescaler appear at the ports as a `poll_req` that arrives a whole number of ticks too early or too late. They show on the very first pulse after an arm, so the bench measures intervals to the exact cycle and does not merely count pulses. Errors in the enable or interval-write logic appear as a pulse that shows up during a window where none is allowed, or as a schedule that has shifted by the time of the write. Errors in the framer's index or buffer logic corrupt the packet from the first wrong byte onward. They also move `pkt_last`, or leave `pkt_valid` high one byte too long, and all of this is visible during the very next read.

// File: rtl/autopoll_pkg.sv
package autopoll_pkg;
   localparam logic [7:0] BUS_PKT_TYPE = 8'h00;
   localparam logic [7:0] POLLED_MARK  = 8'h40;
endpackage

// File: rtl/autopoll_ms_tick.sv
module autopoll_ms_tick #(
   parameter int unsigned TICKS_PER_MS = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic tick
);
   localparam int unsigned CW = $clog2(TICKS_PER_MS);
   localparam logic [CW-1:0] LAST = CW'(TICKS_PER_MS - 1);

   logic [CW-1:0] cnt_q;

   assign tick = run && !restart && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart || !run || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CW'(1);
   end

   // R3
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/autopoll_timer.sv
module autopoll_timer #(
   parameter int unsigned TICKS_PER_MS = 100000,
   parameter int unsigned RATE_W       = 8,
   parameter int unsigned DEF_RATE     = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_wr,
   input  logic              en_val,
   input  logic              rate_wr,
   input  logic [RATE_W-1:0] rate_val,
   output logic              expire,
   output logic              running
);
   logic              run_q;
   logic [RATE_W-1:0] rate_q;
   logic [RATE_W-1:0] left_q;
   logic              en_rise, en_fall, rate_ok, arm, tick;

   assign en_rise = en_wr && en_val && !run_q;
   assign en_fall = en_wr && !en_val && run_q;
   assign rate_ok = rate_wr && (rate_val != '0);
   assign arm     = en_rise || (rate_ok && run_q);
   assign expire  = tick && (left_q == RATE_W'(1));
   assign running = run_q;

   autopoll_ms_tick #(.TICKS_PER_MS(TICKS_PER_MS)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (arm),
      .run     (run_q),
      .tick    (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         rate_q <= RATE_W'(DEF_RATE);
         left_q <= RATE_W'(DEF_RATE);
      end else begin
         if (en_rise)
            run_q <= 1'b1;
         else if (en_fall)
            run_q <= 1'b0;

         if (rate_ok)
            rate_q <= rate_val;

         if (arm)
            left_q <= rate_ok ? rate_val : rate_q;
         else if (expire)
            left_q <= rate_q;
         else if (tick)
            left_q <= left_q - RATE_W'(1);
      end
   end

   // R7
   left_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (left_q != '0));

   // R2
   arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> (left_q == rate_q));

   // R7
   rate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_wr && rate_val == '0) |=> $stable(rate_q));
endmodule

// File: rtl/autopoll_framer.sv
module autopoll_framer
   import autopoll_pkg::*;
#(
   parameter int unsigned MAX_BYTES = 8,
   parameter int unsigned LEN_W     = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   res_valid,
   input  logic [LEN_W-1:0]       res_len,
   input  logic [8*MAX_BYTES-1:0] res_data,
   output logic                   pkt_valid,
   output logic [7:0]             pkt_data,
   output logic                   pkt_last,
   input  logic                   pkt_ready
);
   localparam int unsigned IW = $clog2(MAX_BYTES + 2);

   logic                   busy_q;
   logic [IW-1:0]          idx_q;
   logic [LEN_W-1:0]       len_q;
   logic [8*MAX_BYTES-1:0] buf_q;
   logic [LEN_W-1:0]       len_cl;
   logic [MAX_BYTES-1:0]   lane_hit;
   logic [7:0]             lane_sel;
   logic                   load;

   always_comb begin
      if (res_len > LEN_W'(MAX_BYTES))
         len_cl = LEN_W'(MAX_BYTES);
      else
         len_cl = res_len;
   end

   assign load      = res_valid && (len_cl != '0) && !busy_q;
   assign pkt_valid = busy_q;
   assign pkt_last  = busy_q && (idx_q == (IW'(len_q) + IW'(1)));

   for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
      assign lane_hit[g] = (idx_q == IW'(g + 2));
   end

   always_comb begin
      lane_sel = '0;
      for (int j = 0; j < MAX_BYTES; j++)
         lane_sel = lane_sel | (buf_q[8*j +: 8] & {8{lane_hit[j]}});
   end

   always_comb begin
      if (idx_q == IW'(0))
         pkt_data = BUS_PKT_TYPE;
      else if (idx_q == IW'(1))
         pkt_data = POLLED_MARK;
      else
         pkt_data = lane_sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         len_q  <= '0;
         buf_q  <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         len_q  <= len_cl;
         buf_q  <= res_data;
      end else if (busy_q && pkt_ready) begin
         if (pkt_last)
            busy_q <= 1'b0;
         idx_q <= idx_q + IW'(1);
      end
   end

   // R9
   hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data)));

   // R9
   end_of_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && pkt_ready && pkt_last) |=> !pkt_valid);

   // R11
   drop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && busy_q) |=> ($stable(len_q) && $stable(buf_q)));

   // R12
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> ((idx_q <= IW'(len_q) + IW'(1)) && (len_q <= LEN_W'(MAX_BYTES))));
endmodule

// File: rtl/autopoll_sched.sv
module autopoll_sched #(
   parameter int unsigned CLK_HZ      = 100_000_000,
   parameter int unsigned RATE_W      = 8,
   parameter int unsigned MASK_W      = 16,
   parameter int unsigned MAX_BYTES   = 8,
   parameter int unsigned DEF_RATE_MS = 20,
   localparam int unsigned LEN_W      = $clog2(MAX_BYTES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_en_wr,
   input  logic                   cfg_en,
   input  logic                   cfg_rate_wr,
   input  logic [RATE_W-1:0]      cfg_rate,
   input  logic                   cfg_mask_wr,
   input  logic [MASK_W-1:0]      cfg_mask,
   output logic                   poll_req,
   output logic [MASK_W-1:0]      poll_mask,
   input  logic                   res_valid,
   input  logic [LEN_W-1:0]       res_len,
   input  logic [8*MAX_BYTES-1:0] res_data,
   output logic                   pkt_valid,
   output logic [7:0]             pkt_data,
   output logic                   pkt_last,
   input  logic                   pkt_ready
);
   localparam int unsigned TICKS_PER_MS = CLK_HZ / 1000;

   if (TICKS_PER_MS < 2) begin : g_bad_clk
      $error("CLK_HZ must give at least two cycles per millisecond");
   end
   if (DEF_RATE_MS == 0 || DEF_RATE_MS >= (1 << RATE_W)) begin : g_bad_rate
      $error("DEF_RATE_MS must be non-zero and fit in RATE_W bits");
   end
   if (MAX_BYTES < 1) begin : g_bad_bytes
      $error("MAX_BYTES must be at least one");
   end

   logic              expire, running;
   logic              req_q;
   logic [MASK_W-1:0] mask_q;

   autopoll_timer #(
      .TICKS_PER_MS (TICKS_PER_MS),
      .RATE_W       (RATE_W),
      .DEF_RATE     (DEF_RATE_MS)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_wr    (cfg_en_wr),
      .en_val   (cfg_en),
      .rate_wr  (cfg_rate_wr),
      .rate_val (cfg_rate),
      .expire   (expire),
      .running  (running)
   );

   autopoll_framer #(
      .MAX_BYTES (MAX_BYTES),
      .LEN_W     (LEN_W)
   ) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .res_valid (res_valid),
      .res_len   (res_len),
      .res_data  (res_data),
      .pkt_valid (pkt_valid),
      .pkt_data  (pkt_data),
      .pkt_last  (pkt_last),
      .pkt_ready (pkt_ready)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         mask_q <= '1;
      end else begin
         req_q <= expire;
         if (cfg_mask_wr)
            mask_q <= cfg_mask;
      end
   end

   assign poll_req  = req_q;
   assign poll_mask = mask_q;

   // R3
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_req |=> !poll_req);

   // R4
   stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !running |=> !poll_req);
endmodule

// File: tb/test_autopoll_sched.sv
module test_autopoll_sched;
   localparam int unsigned CLK_HZ = 4000;
   localparam int unsigned T      = CLK_HZ / 1000;
   localparam int unsigned MAXB   = 8;
   localparam int unsigned LW     = $clog2(MAXB + 1);
   localparam int unsigned NVEC   = 4;
   // fields: rate[35:28] mask[27:12] len[11:8] seed[7:0]
   localparam logic [35:0] VEC [NVEC] = '{
      {8'd5,  16'h0001, 4'd1, 8'hA0},
      {8'd3,  16'h8421, 4'd4, 8'h10},
      {8'd12, 16'h00F0, 4'd8, 8'hC3},
      {8'd7,  16'h1234, 4'd2, 8'h55}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_en_wr = 0, cfg_en = 0, cfg_rate_wr = 0, cfg_mask_wr = 0;
   logic [7:0] cfg_rate = '0;
   logic [15:0] cfg_mask = '0;
   logic poll_req;
   logic [15:0] poll_mask;
   logic res_valid = 0;
   logic [LW-1:0] res_len = '0;
   logic [8*MAXB-1:0] res_data = '0;
   logic pkt_valid, pkt_last;
   logic [7:0] pkt_data;
   logic pkt_ready = 0;

   int nvec = 0, nfail = 0, cyc = 0;
   int arm_cyc, poll_cyc, prev_poll;
   bit done = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   autopoll_sched #(.CLK_HZ(CLK_HZ), .MAX_BYTES(MAXB)) i_autopoll_sched (
      .clk(clk), .rst_n(rst_n),
      .cfg_en_wr(cfg_en_wr), .cfg_en(cfg_en),
      .cfg_rate_wr(cfg_rate_wr), .cfg_rate(cfg_rate),
      .cfg_mask_wr(cfg_mask_wr), .cfg_mask(cfg_mask),
      .poll_req(poll_req), .poll_mask(poll_mask),
      .res_valid(res_valid), .res_len(res_len), .res_data(res_data),
      .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_last(pkt_last),
      .pkt_ready(pkt_ready)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_en(input logic v);
      cfg_en_wr = 1; cfg_en = v; arm_cyc = cyc;
      @(negedge clk); cfg_en_wr = 0;
   endtask

   task automatic wr_rate(input logic [7:0] v);
      cfg_rate_wr = 1; cfg_rate = v; arm_cyc = cyc;
      @(negedge clk); cfg_rate_wr = 0;
   endtask

   task automatic wr_mask(input logic [15:0] v);
      cfg_mask_wr = 1; cfg_mask = v;
      @(negedge clk); cfg_mask_wr = 0;
   endtask

   task automatic wait_poll();
      @(negedge clk);
      while (!poll_req) @(negedge clk);
      prev_poll = poll_cyc;
      poll_cyc = cyc;
   endtask

   task automatic respond(input int len, input logic [7:0] seed);
      res_valid = 1; res_len = LW'(len);
      for (int i = 0; i < int'(MAXB); i++) res_data[8*i +: 8] = seed + 8'(i);
      @(negedge clk);
      res_valid = 0;
   endtask

   task automatic read_pkt(input int len, input logic [7:0] seed, input string req);
      int nb;
      logic [7:0] exp;
      nb = (len > int'(MAXB)) ? int'(MAXB) : len;
      pkt_ready = 1;
      for (int j = 0; j < nb + 2; j++) begin
         exp = (j == 0) ? 8'h00 : (j == 1) ? 8'h40 : seed + 8'(j - 2);
         chk(pkt_valid && pkt_data == exp && pkt_last == (j == nb + 1), req,
             {pkt_valid, pkt_last, pkt_data}, {1'b1, (j == nb + 1), exp});
         @(negedge clk);
      end
      chk(!pkt_valid, req, pkt_valid, 0);
      pkt_ready = 0;
   endtask

   task automatic quiet(input int n, input string req);
      bit seen = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (poll_req || pkt_valid) seen = 1;
      end
      chk(!seen, req, seen, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(!poll_req && !pkt_valid && poll_mask == 16'hFFFF, "R1",
          {poll_req, pkt_valid, poll_mask}, 18'h0FFFF);
      quiet(100, "R1 idle");

      // R2 with default 20 ms interval (R1)
      wr_en(1);
      wait_poll();
      chk(poll_cyc - arm_cyc == 20*T + 1, "R2/R1", poll_cyc - arm_cyc, 20*T + 1);
      chk(poll_mask == 16'hFFFF, "R8", poll_mask, 16'hFFFF);
      // R10 empty result: no packet, schedule intact
      respond(0, 8'h00);
      chk(!pkt_valid, "R10", pkt_valid, 0);
      wait_poll();
      chk(poll_cyc - prev_poll == 20*T, "R10/R3", poll_cyc - prev_poll, 20*T);
      respond(2, 8'hE0);
      read_pkt(2, 8'hE0, "R9");

      // vector table: rate restart (R6), mask (R8), framing (R9), period (R3)
      for (int v = 0; v < int'(NVEC); v++) begin
         wr_mask(VEC[v][27:12]);
         wr_rate(VEC[v][35:28]);
         wait_poll();
         chk(poll_cyc - arm_cyc == int'(VEC[v][35:28])*T + 1, "R6",
             poll_cyc - arm_cyc, int'(VEC[v][35:28])*T + 1);
         chk(poll_mask == VEC[v][27:12], "R8", poll_mask, VEC[v][27:12]);
         respond(int'(VEC[v][11:8]), VEC[v][7:0]);
         read_pkt(int'(VEC[v][11:8]), VEC[v][7:0], "R9");
         wait_poll();
         chk(poll_cyc - prev_poll == int'(VEC[v][35:28])*T, "R3",
             poll_cyc - prev_poll, int'(VEC[v][35:28])*T);
      end

      // rate is 7 ms now; R7 zero write, R5 repeated enable, R8 mask write
      repeat (5) @(negedge clk);
      wr_rate(8'd0);
      wr_en(1);
      wr_mask(16'hBEEF);
      wait_poll();
      chk(poll_cyc - prev_poll == 7*T, "R7/R5", poll_cyc - prev_poll, 7*T);
      chk(poll_mask == 16'hBEEF, "R8", poll_mask, 16'hBEEF);

      // R11: packet left pending, second result dropped
      respond(3, 8'h20);
      wait_poll();
      respond(2, 8'h70);
      read_pkt(3, 8'h20, "R11");

      // R12: oversize length clamped
      wait_poll();
      respond(12, 8'h90);
      read_pkt(12, 8'h90, "R12");

      // R4: disable stops polling
      wr_en(0);
      quiet(120, "R4");

      // R6: rate write while disabled only stores
      wr_rate(8'd6);
      quiet(60, "R6 disabled");
      wr_en(1);
      wait_poll();
      chk(poll_cyc - arm_cyc == 6*T + 1, "R6/R2", poll_cyc - arm_cyc, 6*T + 1);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule